// File: doc/BRIEF.md
# Interrupt, Status and Watchdog Controller

This block gathers the interrupt sources of a timekeeping device and folds them into one active-low interrupt line. Three sources feed it: a periodic tick picked from a set of divider taps, an alarm-match pulse, and a power-fail level from an external sense circuit. Each source that fires while enabled sets its own flag in a status byte and pulls the interrupt low. The line stays low until the host reads the status byte. The read clears every flag except the power-fail flag.

A control byte holds the enables, the periodic rate code and a power-down request. Power-down holds the CPU reset, the clock-out enable and the power-supply enable low until any enabled interrupt fires. A watchdog expects the host to pulse chip-enable with no serial clock activity inside the service window. When no such pulse arrives in time, the watchdog drives a fixed-length CPU reset pulse and records the event in the status byte.

Top module: `irqwd_top`

## Requirements
- R1: After reset, `int_n_o`, `cpu_rst_n_o`, `pse_o` and `clkout_en_o` are 1, `ctrl_o` is 0x00 and `stat_o` is 0x10, meaning only the first-time-up flag (bit 4) is set.
- R2: Control bits 3..0 give the periodic rate code s. Code 0 turns the periodic source off. Code s from 1 to 15 selects `tick_i[s-1]`. Taps 0 to 10 run from 2048 Hz down to 2 Hz, halving at each step. Tap 11 is 1 Hz, tap 12 once a minute, tap 13 once an hour and tap 14 once a day. A pulse on any other tap has no effect.
- R3: An `alarm_hit_i` pulse counts only while control bit 4 is 1. Otherwise it leaves `stat_o` and `int_n_o` unchanged.
- R4: Each enabled event sets its status flag and status bit 3 on the next clock edge. Periodic events set bit 0, alarm events bit 1 and power-fail events bit 2. The same edge drives `int_n_o` low, and it stays low until a status read.
- R5: A status read (`stat_rd_i` high for one cycle) returns the current `stat_o`. It then clears bits 6, 4, 3, 1 and 0 and raises `int_n_o`. Bit 2 is kept. Bits 7 and 5 always read 0.
- R6: An event that lands in the same cycle as a status read wins. Its flag, bit 3 and the low `int_n_o` are all present after that edge.
- R7: Writing control bit 5 from 0 to 1 arms the power-fail source. While armed, a high `pwr_fail_i` fires one event and disarms the source. Writing bit 5 as 0 clears status bit 2, and a later write of 1 re-arms the source.
- R8: While control bit 7 is 1, a window of SERVICE_CYC cycles with no valid service ends in a fire. The fire drives `cpu_rst_n_o` low for exactly RESET_CYC cycles and sets status bit 6.
- R9: A valid service is a falling edge of `ce_i` with no change of `sck_i` seen while `ce_i` was high. A valid service restarts the window. A chip-enable pulse that saw a serial clock edge does not restart it.
- R10: Writing control bit 6 as 1 drives `cpu_rst_n_o`, `pse_o` and `clkout_en_o` low. The first enabled interrupt event drives them high again and clears control bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick_i | input | 2**SEL_W-1 | One-cycle divider tap pulses, index s-1 for rate code s |
| alarm_hit_i | input | 1 | One-cycle alarm comparator match |
| pwr_fail_i | input | 1 | Power-fail sense level |
| ce_i | input | 1 | Chip-enable level |
| sck_i | input | 1 | Serial clock level |
| ctrl_wr_i | input | 1 | Control byte write strobe |
| ctrl_wdata_i | input | 8 | Control byte write data |
| stat_rd_i | input | 1 | Status read strobe |
| ctrl_o | output | 8 | Control byte |
| stat_o | output | 8 | Status byte |
| int_n_o | output | 1 | Active-low interrupt |
| cpu_rst_n_o | output | 1 | Active-low CPU reset |
| pse_o | output | 1 | Power-supply enable |
| clkout_en_o | output | 1 | Clock-out enable |

## Verification
The assertions check cycle-level invariants on every cycle:
- an enabled event is flagged on the next edge, and power-down is released after it;
- a read with no competing event clears the periodic flag and raises the interrupt line;
- the power-fail flag survives a read;
- a fire is always followed by an active reset pulse;
- the pulse counter stays in range.

Only the bench scenarios can show the rest:
- the full rate-code sweep, with a wrong-tap pulse at each code;
- the single-shot behaviour of the power-fail source and its re-arm;
- the exact window and pulse lengths of the watchdog;
- the rejection of chip-enable pulses that saw a serial clock edge.

// File: rtl/irqwd_pkg.sv
package irqwd_pkg;
  localparam int CTL_WDOG  = 7;
  localparam int CTL_PDOWN = 6;
  localparam int CTL_PSEN  = 5;
  localparam int CTL_ALEN  = 4;

  localparam int ST_WDOG = 6;
  localparam int ST_FTU  = 4;
  localparam int ST_ANY  = 3;
  localparam int ST_PF   = 2;
  localparam int ST_ALM  = 1;
  localparam int ST_PER  = 0;

  localparam logic [7:0] STAT_RESET = 8'h10;
endpackage

// File: rtl/irqwd_rate_sel.sv
module irqwd_rate_sel #(
  parameter int SEL_W = 4,
  localparam int NTAP = (1 << SEL_W) - 1
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [NTAP-1:0]  tick_i,
  output logic             ev_o
);
  always_comb begin
    ev_o = 1'b0;
    for (int k = 0; k < NTAP; k++) begin
      if (sel_i == SEL_W'(k + 1)) ev_o = tick_i[k];
    end
  end
endmodule

// File: rtl/irqwd_watchdog.sv
module irqwd_watchdog #(
  parameter int SERVICE_CYC = 256,
  parameter int RESET_CYC   = 512,
  localparam int CW = (SERVICE_CYC > 1) ? $clog2(SERVICE_CYC) : 1,
  localparam int RW = $clog2(RESET_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic ce_i,
  input  logic sck_i,
  output logic fire_o,
  output logic wd_rst_o
);
  localparam logic [CW-1:0] LIM = CW'(SERVICE_CYC - 1);

  logic          ce_q, sck_q, sck_seen;
  logic [CW-1:0] wcnt;
  logic [RW-1:0] rcnt;

  wire ce_fall  = ce_q & ~ce_i;
  wire ce_rise  = ~ce_q & ce_i;
  wire sck_edge = ce_i & (sck_i != sck_q);
  wire serviced = ce_fall & ~sck_seen;

  assign fire_o   = en_i & ~serviced & (wcnt == LIM);
  assign wd_rst_o = (rcnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q     <= 1'b0;
      sck_q    <= 1'b0;
      sck_seen <= 1'b0;
      wcnt     <= '0;
      rcnt     <= '0;
    end else begin
      ce_q  <= ce_i;
      sck_q <= sck_i;
      if (ce_rise)       sck_seen <= 1'b0;
      else if (sck_edge) sck_seen <= 1'b1;

      if (!en_i || serviced || wcnt == LIM) wcnt <= '0;
      else                                   wcnt <= wcnt + 1'b1;

      if (fire_o)          rcnt <= RW'(RESET_CYC);
      else if (rcnt != '0) rcnt <= rcnt - 1'b1;
    end
  end

  assert_fire_starts_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    fire_o |=> wd_rst_o);
  assert_pulse_bound_R8: assert property (@(posedge clk) disable iff (rst)
    rcnt <= RW'(RESET_CYC));
  assert_service_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (en_i && serviced) |=> (wcnt == '0));
endmodule

// File: rtl/irqwd_status.sv
module irqwd_status
  import irqwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       per_ev_i,
  input  logic       alm_ev_i,
  input  logic       pf_ev_i,
  input  logic       wd_ev_i,
  input  logic       rd_i,
  input  logic       pf_clr_i,
  output logic [7:0] stat_o,
  output logic       int_n_o
);
  logic per_f, alm_f, pf_f, any_f, ftu_f, wd_f;
  wire  irq_ev = per_ev_i | alm_ev_i | pf_ev_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_f   <= 1'b0;
      alm_f   <= 1'b0;
      pf_f    <= 1'b0;
      any_f   <= 1'b0;
      ftu_f   <= 1'b1;
      wd_f    <= 1'b0;
      int_n_o <= 1'b1;
    end else begin
      per_f   <= per_ev_i | (per_f & ~rd_i);
      alm_f   <= alm_ev_i | (alm_f & ~rd_i);
      pf_f    <= pf_ev_i  | (pf_f  & ~pf_clr_i);
      any_f   <= irq_ev   | (any_f & ~rd_i);
      ftu_f   <= ftu_f & ~rd_i;
      wd_f    <= wd_ev_i  | (wd_f  & ~rd_i);
      int_n_o <= ~(irq_ev | (~int_n_o & ~rd_i));
    end
  end

  always_comb begin
    stat_o          = 8'h00;
    stat_o[ST_WDOG] = wd_f;
    stat_o[ST_FTU]  = ftu_f;
    stat_o[ST_ANY]  = any_f;
    stat_o[ST_PF]   = pf_f;
    stat_o[ST_ALM]  = alm_f;
    stat_o[ST_PER]  = per_f;
  end

  assert_event_flags_R4: assert property (@(posedge clk) disable iff (rst)
    per_ev_i |=> (stat_o[ST_PER] && stat_o[ST_ANY] && !int_n_o));
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !irq_ev && !wd_ev_i) |=> (int_n_o && stat_o[ST_PER] == 1'b0 && stat_o[ST_ALM] == 1'b0));
  assert_pf_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_i && stat_o[ST_PF] && !pf_clr_i) |=> stat_o[ST_PF]);
endmodule

// File: rtl/irqwd_top.sv
module irqwd_top
  import irqwd_pkg::*;
#(
  parameter int SEL_W       = 4,
  parameter int SERVICE_CYC = 256,
  parameter int RESET_CYC   = 512,
  localparam int NTAP = (1 << SEL_W) - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NTAP-1:0] tick_i,
  input  logic            alarm_hit_i,
  input  logic            pwr_fail_i,
  input  logic            ce_i,
  input  logic            sck_i,
  input  logic            ctrl_wr_i,
  input  logic [7:0]      ctrl_wdata_i,
  input  logic            stat_rd_i,
  output logic [7:0]      ctrl_o,
  output logic [7:0]      stat_o,
  output logic            int_n_o,
  output logic            cpu_rst_n_o,
  output logic            pse_o,
  output logic            clkout_en_o
);
  logic [7:0] ctrl;
  logic       pf_armed;
  logic       per_raw, per_ev, alm_ev, pf_ev, any_ev;
  logic       wd_fire, wd_rst;

  irqwd_rate_sel #(.SEL_W(SEL_W)) u_rate (
    .sel_i  (ctrl[SEL_W-1:0]),
    .tick_i (tick_i),
    .ev_o   (per_raw)
  );

  assign per_ev = per_raw;
  assign alm_ev = alarm_hit_i & ctrl[CTL_ALEN];
  assign pf_ev  = pwr_fail_i & pf_armed & ctrl[CTL_PSEN];
  assign any_ev = per_ev | alm_ev | pf_ev;

  wire pf_clr = ctrl_wr_i & ~ctrl_wdata_i[CTL_PSEN];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= 8'h00;
      pf_armed <= 1'b0;
    end else begin
      if (ctrl_wr_i) ctrl <= ctrl_wdata_i;
      if (any_ev)    ctrl[CTL_PDOWN] <= 1'b0;

      if (ctrl_wr_i && !ctrl_wdata_i[CTL_PSEN])                      pf_armed <= 1'b0;
      else if (ctrl_wr_i && ctrl_wdata_i[CTL_PSEN] && !ctrl[CTL_PSEN]) pf_armed <= 1'b1;
      else if (pf_ev)                                                pf_armed <= 1'b0;
    end
  end

  irqwd_status u_stat (
    .clk      (clk),
    .rst      (rst),
    .per_ev_i (per_ev),
    .alm_ev_i (alm_ev),
    .pf_ev_i  (pf_ev),
    .wd_ev_i  (wd_fire),
    .rd_i     (stat_rd_i),
    .pf_clr_i (pf_clr),
    .stat_o   (stat_o),
    .int_n_o  (int_n_o)
  );

  irqwd_watchdog #(.SERVICE_CYC(SERVICE_CYC), .RESET_CYC(RESET_CYC)) u_wdog (
    .clk      (clk),
    .rst      (rst),
    .en_i     (ctrl[CTL_WDOG]),
    .ce_i     (ce_i),
    .sck_i    (sck_i),
    .fire_o   (wd_fire),
    .wd_rst_o (wd_rst)
  );

  assign ctrl_o      = ctrl;
  assign pse_o       = ~ctrl[CTL_PDOWN];
  assign clkout_en_o = ~ctrl[CTL_PDOWN];
  assign cpu_rst_n_o = ~ctrl[CTL_PDOWN] & ~wd_rst;

  assert_wake_on_irq_R10: assert property (@(posedge clk) disable iff (rst)
    any_ev |=> (pse_o && clkout_en_o));
  assert_pdown_entry_R10: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr_i && ctrl_wdata_i[CTL_PDOWN] && !any_ev) |=> (!pse_o && !cpu_rst_n_o));
  assert_alarm_gated_R3: assert property (@(posedge clk) disable iff (rst)
    (alarm_hit_i && !ctrl[CTL_ALEN] && !per_ev && !pf_ev && !stat_o[ST_ALM]) |=> !stat_o[ST_ALM]);
endmodule

// File: tb/test_irqwd_top.sv
module test_irqwd_top;
  localparam int SEL_W = 4;
  localparam int NTAP  = 15;
  localparam int SVC   = 64;
  localparam int RCY   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NTAP-1:0] tick = '0;
  logic alarm = 1'b0, pfail = 1'b0, ce = 1'b0, sck = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] ctrl_o, stat_o;
  logic int_n, cpu_rst_n, pse, clk_en;

  int tests = 0, fails = 0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  irqwd_top #(.SEL_W(SEL_W), .SERVICE_CYC(SVC), .RESET_CYC(RCY)) i_irqwd_top (
    .clk(clk), .rst(rst), .tick_i(tick), .alarm_hit_i(alarm), .pwr_fail_i(pfail),
    .ce_i(ce), .sck_i(sck), .ctrl_wr_i(wr), .ctrl_wdata_i(wdata), .stat_rd_i(rd),
    .ctrl_o(ctrl_o), .stat_o(stat_o), .int_n_o(int_n), .cpu_rst_n_o(cpu_rst_n),
    .pse_o(pse), .clkout_en_o(clk_en)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    wr = 1'b1; wdata = v;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_stat(output logic [7:0] v);
    rd = 1'b1; v = stat_o;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pulse_tap(input int k);
    tick[k] = 1'b1;
    @(negedge clk);
    tick = '0;
  endtask

  task automatic pulse_alarm();
    alarm = 1'b1;
    @(negedge clk);
    alarm = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 stat", stat_o, 8'h10);
    chk("R1 ctrl", ctrl_o, 8'h00);
    chk("R1 outs", {4'h0, int_n, cpu_rst_n, pse, clk_en}, 8'h0F);
    rd_stat(rv);
    chk("R5 ftu read", rv, 8'h10);
    chk("R5 ftu cleared", stat_o, 8'h00);

    // R2 rate sweep
    for (int s = 0; s < 16; s++) begin
      wr_ctrl(8'(s));
      if (s == 0) begin
        for (int k = 0; k < NTAP; k++) pulse_tap(k);
        chk("R2 code0 int", {7'h0, int_n}, 8'h01);
        chk("R2 code0 stat", stat_o, 8'h00);
      end else begin
        pulse_tap(s % NTAP);
        chk("R2 wrong tap int", {7'h0, int_n}, 8'h01);
        chk("R2 wrong tap stat", stat_o, 8'h00);
        pulse_tap(s - 1);
        chk("R4 tap int", {7'h0, int_n}, 8'h00);
        chk("R2 tap stat", stat_o, 8'h09);
        rd_stat(rv);
        chk("R5 read value", rv, 8'h09);
        chk("R5 after read", stat_o, 8'h00);
        chk("R5 int released", {7'h0, int_n}, 8'h01);
      end
    end

    // R3 alarm gating
    wr_ctrl(8'h00);
    pulse_alarm();
    chk("R3 alarm off stat", stat_o, 8'h00);
    chk("R3 alarm off int", {7'h0, int_n}, 8'h01);
    wr_ctrl(8'h10);
    pulse_alarm();
    chk("R3 alarm on stat", stat_o, 8'h0A);
    chk("R4 alarm int", {7'h0, int_n}, 8'h00);
    repeat (4) @(negedge clk);
    chk("R4 int held", {7'h0, int_n}, 8'h00);
    rd_stat(rv);
    chk("R5 alarm cleared", stat_o, 8'h00);

    // R6 event and read in same cycle
    alarm = 1'b1; rd = 1'b1; rv = stat_o;
    @(negedge clk);
    alarm = 1'b0; rd = 1'b0;
    chk("R6 read value", rv, 8'h00);
    chk("R6 event kept", stat_o, 8'h0A);
    chk("R6 int low", {7'h0, int_n}, 8'h00);
    rd_stat(rv);

    // R7 power-sense one-shot and re-arm
    wr_ctrl(8'h20);
    pfail = 1'b1;
    @(negedge clk);
    chk("R7 pf stat", stat_o, 8'h0C);
    chk("R7 pf int", {7'h0, int_n}, 8'h00);
    rd_stat(rv);
    chk("R5 pf kept", stat_o, 8'h04);
    repeat (5) @(negedge clk);
    chk("R7 one shot", {7'h0, int_n}, 8'h01);
    wr_ctrl(8'h00);
    chk("R7 pf cleared", stat_o, 8'h00);
    wr_ctrl(8'h20);
    @(negedge clk);
    chk("R7 rearmed", stat_o, 8'h0C);
    pfail = 1'b0;
    wr_ctrl(8'h00);
    rd_stat(rv);
    chk("R7 idle", stat_o, 8'h00);

    // R10 power down
    wr_ctrl(8'h50);
    chk("R10 pd outs", {5'h0, cpu_rst_n, pse, clk_en}, 8'h00);
    repeat (3) @(negedge clk);
    chk("R10 pd held", {5'h0, cpu_rst_n, pse, clk_en}, 8'h00);
    pulse_alarm();
    chk("R10 wake outs", {5'h0, cpu_rst_n, pse, clk_en}, 8'h07);
    chk("R10 ctrl bit", ctrl_o, 8'h10);
    rd_stat(rv);
    wr_ctrl(8'h00);

    // R8 watchdog expiry
    begin
      int first = -1, lowlen = 0;
      wr_ctrl(8'h80);
      for (int n = 1; n <= SVC + RCY + 4; n++) begin
        @(negedge clk);
        if (!cpu_rst_n) begin
          if (first < 0) first = n;
          lowlen++;
        end
      end
      chk("R8 fire cycle", 8'(first), 8'(SVC));
      chk("R8 pulse length", 8'(lowlen), 8'(RCY));
      wr_ctrl(8'h00);
      chk("R8 wd flag", stat_o, 8'h40);
      rd_stat(rv);
      chk("R5 wd cleared", stat_o, 8'h00);
    end

    // R9 clean service keeps reset away
    begin
      int lows = 0;
      wr_ctrl(8'h80);
      for (int p = 0; p < 5; p++) begin
        repeat (25) begin @(negedge clk); if (!cpu_rst_n) lows++; end
        ce = 1'b1;
        repeat (3) begin @(negedge clk); if (!cpu_rst_n) lows++; end
        ce = 1'b0;
      end
      chk("R9 clean service", 8'(lows), 8'h00);
    end

    // R9 pulses with sck activity do not service
    begin
      int first = -1;
      for (int n = 1; n <= SVC + 8; n++) begin
        @(negedge clk);
        if (!cpu_rst_n && first < 0) first = n;
        if (n == 10 || n == 40) ce = 1'b1;
        if (n == 12 || n == 42) sck = ~sck;
        if (n == 14 || n == 44) ce = 1'b0;
      end
      chk("R9 dirty pulse ignored", 8'(first), 8'(SVC + 1));
      wr_ctrl(8'h00);
      chk("R9 wd flag", stat_o & 8'h40, 8'h40);
      rd_stat(rv);
    end

    repeat (RCY + 2) @(negedge clk);
    chk("R8 reset released", {7'h0, cpu_rst_n}, 8'h01);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule